// File: doc/BRIEF.md
# System Call Entry Unit

This unit commits the privileged-state side effects of a system call at the moment the call retires. It supports two forms. The plain form saves the return address and a filtered copy of the machine state into the save/restore pair (SRR0, SRR1) and steers execution to one fixed entry vector. The vectored form puts the return address into the link register instead, and it picks its entry point from a table of vectors indexed by the 7-bit level field of the instruction.

In both forms the new machine state comes from a fixed entry mask applied to the current machine state. The mask drops problem state, external interrupt enable and both relocation enables. Every result is held in a register. A one-cycle retire strobe causes the update, so the values appear on the outputs right after the rising clock edge that samples the strobe high. Bit numbers in this brief count from the most significant end, so bit 0 is the MSB of a 64-bit value and bit 63 is the LSB.

Top module: `syscall_entry`

## Requirements
- R1: While reset is asserted and directly after it, srr0Q, srr1Q, lrQ, msrQ and nextAddr all read zero.
- R2: A plain call (isVectored=0) loads srr0Q with curAddr+4, wrapping modulo 2^64, and leaves lrQ unchanged.
- R3: A plain call writes zero into srr1Q bits 33–36 and 42–47.
- R4: Either call form copies msrIn bits 0–32, 37–41 and 48–63 into the same positions of srr1Q.
- R5: A plain call sets nextAddr to 0x0000_0000_0000_0C00, whatever the level input holds.
- R6: A vectored call (isVectored=1) loads lrQ with curAddr+4, wrapping modulo 2^64, and leaves srr0Q unchanged. In this form the value of srr1Q bits 33–36 and 42–47 is unspecified.
- R7: Either call form loads msrQ with msrIn, except that bits 48, 49, 58 and 59 are forced to zero. All other bits, including bits 3 and 51, pass through unchanged.
- R8: A vectored call sets nextAddr to 0x17000 + (level << 5).
- R9: Each update happens in the cycle in which retire is high. While retire is low, all five outputs keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire | input | 1 | High for one cycle when a system call retires |
| isVectored | input | 1 | 0 selects the plain form, 1 selects the vectored form |
| level | input | 7 | Level field of the call instruction |
| curAddr | input | 64 | Address of the retiring call instruction |
| msrIn | input | 64 | Current machine state |
| srr0Q | output | 64 | Saved return address (plain form) |
| srr1Q | output | 64 | Saved machine state |
| lrQ | output | 64 | Link register (vectored form) |
| msrQ | output | 64 | Machine state after the call |
| nextAddr | output | 64 | Entry address to fetch next |

## Verification
A table of calls drives both forms with machine-state patterns of all ones, all zeros and mixed bits. The all-ones pattern shows whether the forced-zero SRR1 gaps and the four entry-cleared bits fall at the right positions, because every other bit is set. Mixed patterns catch ranges that are shifted or reversed. Addresses close to 2^64 show whether the return address wraps. Level values of 0, 1, 0x55 and 127 separate a wrong shift from a missing base, and they also show that the plain form ignores the level. Directed steps change every input while retire is low to confirm that nothing moves, then assert reset partway through the run.

// File: rtl/sysc_pkg.sv
`timescale 1ns/1ps
package sysc_pkg;
  localparam int XLEN       = 64;
  localparam int LVL_W      = 7;
  localparam int INSN_BYTES = 4;
  localparam int VEC_SHIFT  = 5;
  localparam logic [XLEN-1:0] PLAIN_VEC = 64'h0000_0000_0000_0C00;
  localparam logic [XLEN-1:0] VEC_BASE  = 64'h0000_0000_0001_7000;

  // Mask for an inclusive MSB-first bit range [lo..hi]
  function automatic logic [XLEN-1:0] msbRange(input int lo, input int hi);
    logic [XLEN-1:0] m;
    m = '0;
    for (int k = 0; k < XLEN; k++)
      if (k >= lo && k <= hi) m[XLEN-1-k] = 1'b1;
    return m;
  endfunction

  localparam logic [XLEN-1:0] SRR1_GAP  = msbRange(33, 36) | msbRange(42, 47);
  localparam logic [XLEN-1:0] SRR1_COPY = ~SRR1_GAP;
  localparam logic [XLEN-1:0] MSR_CLEAR = msbRange(48, 49) | msbRange(58, 59);

  typedef struct packed {
    logic ldSrr0;
    logic ldLr;
    logic ldSrr1;
    logic zeroGap;
    logic ldMsr;
    logic ldNia;
    logic useLevel;
  } strobes_t;
endpackage

// File: rtl/sysc_ctrl.sv
`timescale 1ns/1ps
module sysc_ctrl
  import sysc_pkg::*;
(
  input  logic     retire,
  input  logic     isVectored,
  output strobes_t stb
);
  always_comb begin
    stb = '0;
    if (retire) begin
      stb.ldSrr1   = 1'b1;
      stb.ldMsr    = 1'b1;
      stb.ldNia    = 1'b1;
      stb.ldSrr0   = !isVectored;
      stb.zeroGap  = !isVectored;
      stb.ldLr     = isVectored;
      stb.useLevel = isVectored;
    end
  end
endmodule

// File: rtl/sysc_datapath.sv
`timescale 1ns/1ps
module sysc_datapath
  import sysc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobes_t      stb,
  input  logic [LW-1:0] level,
  input  logic [W-1:0]  curAddr,
  input  logic [W-1:0]  msrIn,
  output logic [W-1:0]  srr0Q,
  output logic [W-1:0]  srr1Q,
  output logic [W-1:0]  lrQ,
  output logic [W-1:0]  msrQ,
  output logic [W-1:0]  niaQ
);
  logic [W-1:0] retAddr;
  logic [W-1:0] target;
  logic [W-1:0] gapBits;

  assign retAddr = curAddr + W'(INSN_BYTES);
  assign target  = stb.useLevel ? (VEC_BASE + (W'(level) << VEC_SHIFT)) : PLAIN_VEC;
  // vectored form leaves the undefined gap bits as they were
  assign gapBits = stb.zeroGap ? '0 : (srr1Q & SRR1_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srr0Q <= '0;
      srr1Q <= '0;
      lrQ   <= '0;
      msrQ  <= '0;
      niaQ  <= '0;
    end else begin
      if (stb.ldSrr0) srr0Q <= retAddr;
      if (stb.ldLr)   lrQ   <= retAddr;
      if (stb.ldSrr1) srr1Q <= (msrIn & SRR1_COPY) | gapBits;
      if (stb.ldMsr)  msrQ  <= msrIn & ~MSR_CLEAR;
      if (stb.ldNia)  niaQ  <= target;
    end
  end
endmodule

// File: rtl/syscall_entry.sv
`timescale 1ns/1ps
module syscall_entry
  import sysc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        retire,
  input  logic        isVectored,
  input  logic [6:0]  level,
  input  logic [63:0] curAddr,
  input  logic [63:0] msrIn,
  output logic [63:0] srr0Q,
  output logic [63:0] srr1Q,
  output logic [63:0] lrQ,
  output logic [63:0] msrQ,
  output logic [63:0] nextAddr
);
  strobes_t stb;

  sysc_ctrl ctrl (
    .retire(retire), .isVectored(isVectored), .stb(stb)
  );

  sysc_datapath #(.W(XLEN), .LW(LVL_W)) dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .level(level),
    .curAddr(curAddr), .msrIn(msrIn),
    .srr0Q(srr0Q), .srr1Q(srr1Q), .lrQ(lrQ), .msrQ(msrQ), .niaQ(nextAddr)
  );

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> ($stable(srr0Q) && $stable(srr1Q) && $stable(lrQ) &&
                 $stable(msrQ) && $stable(nextAddr)));

  assert_lr_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !isVectored) |=> $stable(lrQ));

  assert_gap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !isVectored) |=> ((srr1Q & SRR1_GAP) == '0));

  assert_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (((srr1Q ^ $past(msrIn)) & SRR1_COPY) == '0));

  assert_plain_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !isVectored) |=> (nextAddr == PLAIN_VEC));

  assert_srr0_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && isVectored) |=> $stable(srr0Q));

  assert_msr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> ((msrQ & MSR_CLEAR) == '0));

  assert_vec_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && isVectored) |=> (nextAddr[4:0] == 5'd0 && nextAddr[63:12] == 52'h17));
endmodule

// File: tb/syscall_entry_test.sv
`timescale 1ns/1ps
module syscall_entry_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire = 1'b0;
  logic        isVectored = 1'b0;
  logic [6:0]  level = '0;
  logic [63:0] curAddr = '0;
  logic [63:0] msrIn = '0;
  logic [63:0] srr0Q, srr1Q, lrQ, msrQ, nextAddr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  syscall_entry uut (
    .clk(clk), .rst_n(rst_n), .retire(retire), .isVectored(isVectored),
    .level(level), .curAddr(curAddr), .msrIn(msrIn),
    .srr0Q(srr0Q), .srr1Q(srr1Q), .lrQ(lrQ), .msrQ(msrQ), .nextAddr(nextAddr)
  );

  localparam int NV = 6;
  localparam logic        T_VEC [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [6:0]  T_LVL [NV] = '{7'd0, 7'd0, 7'h55, 7'd127, 7'd127, 7'd1};
  localparam logic [63:0] T_ADR [NV] = '{
    64'h0000_0000_0000_1000, 64'h2000_0000_0000_0100, 64'h0000_7FFF_FFFF_FFF0,
    64'h0000_0000_0000_0044, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0000_0000_0000_0010};
  localparam logic [63:0] T_MSR [NV] = '{
    64'h8000_0000_0000_F033, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0000, 64'h0F0F_0F0F_0F0F_0F0F};

  // bench-side masks, from MSB-first bit numbers
  function automatic logic [63:0] gapMask();
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++) begin
      int k = 63 - i;
      if ((k >= 33 && k <= 36) || (k >= 42 && k <= 47)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [63:0] clrMask();
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++) begin
      int k = 63 - i;
      if (k == 48 || k == 49 || k == 58 || k == 59) m[i] = 1'b1;
    end
    return m;
  endfunction

  logic [63:0] eSrr0 = '0, eSrr1 = '0, eLr = '0, eMsr = '0, eNia = '0;
  bit srr1GapKnown = 1'b1;

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic checkAll(input string req);
    logic [63:0] cm;
    cm = srr1GapKnown ? 64'hFFFF_FFFF_FFFF_FFFF : ~gapMask();
    check(req, "srr0Q", srr0Q, eSrr0);
    check(req, "srr1Q", srr1Q & cm, eSrr1 & cm);
    check(req, "lrQ", lrQ, eLr);
    check(req, "msrQ", msrQ, eMsr);
    check(req, "nextAddr", nextAddr, eNia);
  endtask

  task automatic doCall(input logic v, input logic [6:0] l,
                        input logic [63:0] a, input logic [63:0] m);
    @(negedge clk);
    isVectored = v; level = l; curAddr = a; msrIn = m; retire = 1'b1;
    @(negedge clk);
    retire = 1'b0;
    if (v) begin
      eLr = a + 64'd4;
      eNia = 64'h17000 + (64'(l) << 5);
      srr1GapKnown = 1'b0;
    end else begin
      eSrr0 = a + 64'd4;
      eNia = 64'h0C00;
      srr1GapKnown = 1'b1;
    end
    eSrr1 = m & ~gapMask();
    eMsr = m & ~clrMask();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checkAll("R1");
    rst_n = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int t = 0; t < NV; t++) begin
      doCall(T_VEC[t], T_LVL[t], T_ADR[t], T_MSR[t]);
      checkAll(T_VEC[t] ? "R6/R8/R4/R7" : "R2/R3/R5/R4/R7");
    end

    // R5: plain call ignores level, R3 after a vectored call
    doCall(1'b0, 7'h7F, 64'h0000_0000_0000_3000, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R5", "nextAddr", nextAddr, 64'h0C00);
    check("R3", "srr1Q gap", srr1Q & gapMask(), 64'h0);
    check("R7", "msrQ bits3/51 kept", msrQ & 64'h1000_0000_0000_1000,
          64'h1000_0000_0000_1000);

    // R9: inputs move with retire low
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      isVectored = c[0]; level = 7'(c * 9); curAddr = 64'hABCD_0000 + 64'(c);
      msrIn = ~msrIn;
    end
    @(negedge clk);
    checkAll("R9");

    // R8: top level value
    doCall(1'b1, 7'd127, 64'h0, 64'h0);
    check("R8", "nextAddr", nextAddr, 64'h0001_7FE0);
    check("R6", "lrQ", lrQ, 64'h4);

    // R1: mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    eSrr0 = '0; eSrr1 = '0; eLr = '0; eMsr = '0; eNia = '0;
    srr1GapKnown = 1'b1;
    @(negedge clk);
    checkAll("R1");
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule